// File: doc/BRIEF.md
# Shared-Pin Strap Capture and LED Polarity Controller

This block lets five package pins serve two purposes. While the chip is held in reset the pins are inputs, and the board sets their levels with optional pull-down resistors. When reset ends, the block samples those levels into a 5-bit device address. From then on the same pins become outputs: four show status LEDs, and the fifth is a general-purpose output.

Each LED's active level follows the level that was sampled on its own pin. A pin that read high drives its LED active low, so the pull-up side of the LED stays valid. A pin that read low drives its LED active high. A separate mode strap is captured at the same moment. Its high default selects interrupt-output mode, and a low level selects the extended transmit data/error mode.

The release of the asynchronous reset is first synchronised to the clock. The pins are sampled on the clock edge at which the synchronised reset deasserts. The output enables turn on one clock after that edge.

Top module: `strap_led_ctrl`

## Requirements
- R1: The pins are sampled on the clock edge at which the synchronised reset deasserts. With the default two synchroniser stages, this is the second rising clock edge after `rst_n` goes high.
- R2: Address bits 0 to 3 come from `pin_in[0]` to `pin_in[3]` (the LED pins, in order). Address bit 4 comes from `pin_in[4]` (the general-purpose output pin).
- R3: From reset until the capture, `phy_addr` reads 5'b11111, `mode_strap` reads 1 and `led_pol_lo` reads 4'b1111.
- R4: After the capture, `phy_addr`, `mode_strap` and `led_pol_lo` stay constant until the next reset, whatever the pins do.
- R5: When a LED pin's strap was sampled high, `led_pol_lo[i]` is 1 and the enabled `pin_out[i]` equals the inverse of `led_req[i]`, so an asserted LED drives the pin low.
- R6: When a LED pin's strap was sampled low, `led_pol_lo[i]` is 0 and the enabled `pin_out[i]` equals `led_req[i]`, so an asserted LED drives the pin high.
- R7: Once enabled, `pin_out[4]` equals `gpo_req` without inversion, whatever level its strap had.
- R8: `pin_oe` is 5'b00000 and `pin_out` is 5'b00000 during reset, on the capture edge and before it. `pin_oe` becomes 5'b11111 on the clock edge after the capture.
- R9: `mode_strap` holds the level of `mode_pin_in` sampled at the capture edge. 1 selects interrupt-output mode and 0 selects the extended transmit mode.
- R10: A new reset clears the block back to the R3 values. A new release captures the strap levels present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| pin_in | input | 5 | Pad input levels: bits 0-3 are the LED pins, bit 4 is the general-purpose pin |
| mode_pin_in | input | 1 | Pad input level of the mode strap |
| led_req | input | 4 | LED on requests, active high |
| gpo_req | input | 1 | Level requested on the general-purpose pin |
| pin_out | output | 5 | Pad output levels |
| pin_oe | output | 5 | Pad output enables, active high |
| phy_addr | output | 5 | Latched device address |
| mode_strap | output | 1 | Latched mode strap (1 = interrupt-output mode) |
| led_pol_lo | output | 4 | Latched LED polarity per pin (1 = active low) |

## Verification
Straps are applied as all high, all low, alternating patterns and a walking zero. These patterns separate correct bit-to-pin mapping from swapped or shifted mappings, and show whether the polarity is kept per pin or shared. Each capture is checked one cycle before and one cycle after the sampling edge, so early or late sampling is caught. The pins are then flipped to reveal any re-sampling. LED and general-purpose requests are swept through on and off under each polarity. A second reset with different straps shows that recapture works.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
    localparam int LED_N    = 4;
    localparam int STRAP_W  = LED_N + 1;
    localparam int GPO_IDX  = LED_N;

    typedef struct packed {
        logic [STRAP_W-1:0] addr;
        logic [LED_N-1:0]   pol_lo;
        logic               mode;
        logic               done;
    } cap_state_t;

    typedef struct packed {
        logic en;
    } drv_state_t;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rel_n_o,
    output logic cap_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rel_n_o = sync_q[LAST];
    // The edge that raises the last stage is the capture edge.
    assign cap_o   = sync_q[LAST-1] & ~sync_q[LAST];

    a_r1_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rel_n_o |=> rel_n_o);
    a_r1_cap_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |=> rel_n_o);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_led_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_i,
    input  logic [STRAP_W-1:0] pin_i,
    input  logic               mode_i,
    output logic [STRAP_W-1:0] addr_o,
    output logic [LED_N-1:0]   pol_lo_o,
    output logic               mode_o,
    output logic               done_o
);
    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i && !st_q.done) begin
            st_d.addr   = pin_i;
            st_d.pol_lo = pin_i[LED_N-1:0];
            st_d.mode   = mode_i;
            st_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr   <= '1;
            st_q.pol_lo <= '1;
            st_q.mode   <= 1'b1;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o   = st_q.addr;
    assign pol_lo_o = st_q.pol_lo;
    assign mode_o   = st_q.mode;
    assign done_o   = st_q.done;

    a_r4_hold_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> ($stable(addr_o) && $stable(pol_lo_o) && $stable(mode_o)));
    a_r1_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !cap_i);
    a_r3_defaults_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> (addr_o == '1 && pol_lo_o == '1 && mode_o));
endmodule

// File: rtl/strap_led_drive.sv
module strap_led_drive
    import strap_led_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_i,
    input  logic [LED_N-1:0]   pol_lo_i,
    input  logic [LED_N-1:0]   led_req_i,
    input  logic               gpo_req_i,
    output logic [STRAP_W-1:0] pin_o,
    output logic [STRAP_W-1:0] oe_o
);
    drv_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = st_q.en | done_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < LED_N; i++) begin : g_led
        assign pin_o[i] = st_q.en & (led_req_i[i] ^ pol_lo_i[i]);
    end
    assign pin_o[GPO_IDX] = st_q.en & gpo_req_i;
    assign oe_o           = {STRAP_W{st_q.en}};

    a_r8_enable_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.en) |-> $past(done_i));
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
    import strap_led_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] pin_in,
    input  logic               mode_pin_in,
    input  logic [LED_N-1:0]   led_req,
    input  logic               gpo_req,
    output logic [STRAP_W-1:0] pin_out,
    output logic [STRAP_W-1:0] pin_oe,
    output logic [STRAP_W-1:0] phy_addr,
    output logic               mode_strap,
    output logic [LED_N-1:0]   led_pol_lo
);
    logic rel_n, cap, done;

    strap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rel_n_o (rel_n),
        .cap_o   (cap)
    );

    strap_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .pin_i    (pin_in),
        .mode_i   (mode_pin_in),
        .addr_o   (phy_addr),
        .pol_lo_o (led_pol_lo),
        .mode_o   (mode_strap),
        .done_o   (done)
    );

    strap_led_drive u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done),
        .pol_lo_i  (led_pol_lo),
        .led_req_i (led_req),
        .gpo_req_i (gpo_req),
        .pin_o     (pin_out),
        .oe_o      (pin_oe)
    );

    a_r8_no_drive_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_n |-> (pin_oe == '0 && pin_out == '0));
    a_r7_gpo_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[GPO_IDX] |-> (pin_out[GPO_IDX] == gpo_req));
    a_r2_pol_tracks_addr: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (led_pol_lo == phy_addr[LED_N-1:0]));
endmodule

// File: tb/strap_led_ctrl_tb.sv
module strap_led_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pin_in = 5'h1F;
    logic       mode_pin_in = 1'b1;
    logic [3:0] led_req = 4'h0;
    logic       gpo_req = 1'b0;
    logic [4:0] pin_out, pin_oe, phy_addr;
    logic       mode_strap;
    logic [3:0] led_pol_lo;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    strap_led_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode_pin_in(mode_pin_in),
        .led_req(led_req), .gpo_req(gpo_req), .pin_out(pin_out), .pin_oe(pin_oe),
        .phy_addr(phy_addr), .mode_strap(mode_strap), .led_pol_lo(led_pol_lo)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reset with straps applied; returns after the capture edge at a negedge.
    task automatic reset_and_capture(input logic [4:0] straps, input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        pin_in = straps;
        mode_pin_in = mode;
        repeat (3) @(negedge clk);
        check("R3", "addr in reset", {3'b0, phy_addr}, 8'h1F);
        check("R8", "oe in reset", {3'b0, pin_oe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);              // after first edge: not yet captured
        check("R1", "addr before capture edge", {3'b0, phy_addr}, 8'h1F);
        check("R8", "oe before capture", {3'b0, pin_oe}, 8'h00);
        @(negedge clk);              // after capture edge
        check("R2", "captured addr", {3'b0, phy_addr}, {3'b0, straps});
        check("R9", "mode strap", {7'b0, mode_strap}, {7'b0, mode});
        check("R8", "oe on capture edge", {3'b0, pin_oe}, 8'h00);
        check("R8", "out on capture edge", {3'b0, pin_out}, 8'h00);
        pin_in = ~straps;
        mode_pin_in = ~mode;
        @(negedge clk);
        check("R8", "oe after capture", {3'b0, pin_oe}, 8'h1F);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        pin_in = 5'h00;
        mode_pin_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R3", "reset addr", {3'b0, phy_addr}, 8'h1F);
        check("R3", "reset mode", {7'b0, mode_strap}, 8'h01);
        check("R3", "reset pol", {4'b0, led_pol_lo}, 8'h0F);
        check("R8", "reset oe", {3'b0, pin_oe}, 8'h00);
        check("R8", "reset out", {3'b0, pin_out}, 8'h00);
    endtask

    task automatic t_polarity(input logic [4:0] straps);
        for (int r = 0; r < 16; r++) begin
            led_req = r[3:0];
            gpo_req = r[0];
            #1;
            for (int i = 0; i < 4; i++) begin
                if (straps[i])
                    check("R5", "active-low led", {7'b0, pin_out[i]}, {7'b0, ~led_req[i]});
                else
                    check("R6", "active-high led", {7'b0, pin_out[i]}, {7'b0, led_req[i]});
            end
            check("R7", "gpo passthrough", {7'b0, pin_out[4]}, {7'b0, gpo_req});
        end
        check("R5", "pol vector", {4'b0, led_pol_lo}, {4'b0, straps[3:0]});
    endtask

    task automatic t_hold(input logic [4:0] straps, input logic mode);
        for (int k = 0; k < 8; k++) begin
            pin_in = 5'(k * 7);
            mode_pin_in = k[0];
            @(negedge clk);
        end
        check("R4", "addr held", {3'b0, phy_addr}, {3'b0, straps});
        check("R4", "pol held", {4'b0, led_pol_lo}, {4'b0, straps[3:0]});
        check("R4", "mode held", {7'b0, mode_strap}, {7'b0, mode});
    endtask

    task automatic t_scenario(input logic [4:0] straps, input logic mode);
        reset_and_capture(straps, mode);
        t_polarity(straps);
        t_hold(straps, mode);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_scenario(5'h1F, 1'b1);       // all floating high
        t_scenario(5'h00, 1'b0);       // all pulled low
        t_scenario(5'h15, 1'b1);       // alternating
        t_scenario(5'h0A, 1'b0);       // alternating, other phase
        for (int w = 0; w < 5; w++)    // walking zero; R10 recapture each time
            t_scenario(~(5'h01 << w), w[0]);
        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule